// File: doc/BRIEF.md
# Dual-Core Lockstep Bus Comparator

This block watches the bus-master outputs of two identical processors that run the same program in lockstep, cycle by cycle. Only core 0 reaches the shared memory bus. Core 1 is a shadow that exists only to be compared against. On the data side the block compares request, write strobe, address, byte enables and write data. On the instruction side it compares fetch request and fetch address. A comparison is made only in a cycle where at least one core asserts the request on that side.

When the two cores disagree, a small state machine leaves its running state. It raises a sticky divergence flag, which can drive an external indicator, and requests a processor reset. It stays there until the reset controller acknowledges. A saturating event counter records every diverging cycle. Fault-insertion inputs can XOR a bit mask onto one core's addresses and write data, so a test can prove that the checker works.

State machine: `ST_RUN` (comparing, no reset request) and `ST_HOLD` (divergence latched, reset requested). Transitions: `ST_RUN -> ST_HOLD` on any diverging cycle. `ST_HOLD -> ST_RUN` on `rst_ack`. `ST_HOLD` stays in `ST_HOLD` while `rst_ack` is low, whatever the cores do. `ST_RUN` stays in `ST_RUN` on an agreeing or idle cycle.

Top module: `lockstep_cmp`

## Requirements
- R1: After reset, `diverged` and `core_rst_req` are 0 and `div_count` is 0.
- R2: The bus outputs (`bus_d_*`, `bus_i_*`) are a combinational copy of core 0's signals after fault insertion. Core 1's signals never reach them.
- R3: In a cycle where either `c0_d_req` or `c1_d_req` is 1, the data side diverges if request, `d_we`, `d_addr` or `d_be` differ. It also diverges if `d_wdata` differs while either core has `d_we` = 1. One clock edge later, `diverged` and `core_rst_req` read 1.
- R4: In a cycle where either `c0_i_req` or `c1_i_req` is 1, the instruction side diverges if the requests or `i_addr` differ. The result is seen one edge later, as in R3.
- R5: Differences on a side whose two requests are both 0 are ignored. A `d_wdata` difference on a read (both `d_we` = 0) is also ignored. Neither sets `diverged` nor changes `div_count`.
- R6: When `fi_en` = 1, the core selected by `fi_core` (0 = core 0, 1 = core 1) has `fi_addr_mask` XORed onto its `d_addr` and `i_addr`, and `fi_data_mask` XORed onto its `d_wdata`. With `fi_en` = 0 the masks have no effect.
- R7: `diverged` and `core_rst_req` stay 1 in every cycle until a cycle with `rst_ack` = 1. They read 0 after that edge, even if the cores diverge in the acknowledge cycle. `rst_ack` while running has no effect.
- R8: `div_count` (8 bits) increments by 1 on every diverging cycle, including cycles in `ST_HOLD`. It saturates at 255 and is cleared only by `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c0_d_req | input | 1 | Core 0 data request |
| c0_d_we | input | 1 | Core 0 data write strobe |
| c0_d_addr | input | AW | Core 0 data address |
| c0_d_wdata | input | DW | Core 0 write data |
| c0_d_be | input | DW/8 | Core 0 byte enables |
| c0_i_req | input | 1 | Core 0 fetch request |
| c0_i_addr | input | AW | Core 0 fetch address |
| c1_d_req | input | 1 | Core 1 data request |
| c1_d_we | input | 1 | Core 1 data write strobe |
| c1_d_addr | input | AW | Core 1 data address |
| c1_d_wdata | input | DW | Core 1 write data |
| c1_d_be | input | DW/8 | Core 1 byte enables |
| c1_i_req | input | 1 | Core 1 fetch request |
| c1_i_addr | input | AW | Core 1 fetch address |
| fi_en | input | 1 | Fault insertion enable |
| fi_core | input | 1 | Core receiving the fault |
| fi_addr_mask | input | AW | XOR mask for addresses |
| fi_data_mask | input | DW | XOR mask for write data |
| rst_ack | input | 1 | Reset controller acknowledge |
| bus_d_req | output | 1 | Forwarded data request |
| bus_d_we | output | 1 | Forwarded write strobe |
| bus_d_addr | output | AW | Forwarded data address |
| bus_d_wdata | output | DW | Forwarded write data |
| bus_d_be | output | DW/8 | Forwarded byte enables |
| bus_i_req | output | 1 | Forwarded fetch request |
| bus_i_addr | output | AW | Forwarded fetch address |
| diverged | output | 1 | Sticky divergence indicator |
| core_rst_req | output | 1 | Processor reset request |
| div_count | output | CW | Saturating divergence counter |

## Verification
The bench flips every single address bit, write-data bit and byte enable on core 1, one at a time, along with each request and strobe. A comparator that drops or miswires a bit lane would miss one of these cycles. Write data that differs on reads, and addresses that differ while both cores are idle, must leave the flag and counter untouched. A comparator that ignores the request gating would raise false alarms here. Fault masks are walked over both cores, and the forwarded bus is checked to carry core 0's corrupted address. Holding a divergence across the acknowledge and driving 300 consecutive diverging cycles exposes a flag that is not sticky, an acknowledge that loses to a new divergence, and a counter that wraps instead of saturating.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } lsc_state_e;

    localparam int NUM_CORES = 2;

endpackage

// File: rtl/lsc_fault_inj.sv
module lsc_fault_inj #(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int CORE_ID = 0
) (
    input  logic          fi_en,
    input  logic          fi_core,
    input  logic [AW-1:0] fi_addr_mask,
    input  logic [DW-1:0] fi_data_mask,
    input  logic [AW-1:0] d_addr_in,
    input  logic [DW-1:0] d_wdata_in,
    input  logic [AW-1:0] i_addr_in,
    output logic [AW-1:0] d_addr_out,
    output logic [DW-1:0] d_wdata_out,
    output logic [AW-1:0] i_addr_out
);
    localparam logic MY_SEL = (CORE_ID != 0);

    logic hit;

    always_comb begin
        hit         = fi_en && (fi_core == MY_SEL);
        d_addr_out  = hit ? (d_addr_in  ^ fi_addr_mask) : d_addr_in;
        i_addr_out  = hit ? (i_addr_in  ^ fi_addr_mask) : i_addr_in;
        d_wdata_out = hit ? (d_wdata_in ^ fi_data_mask) : d_wdata_in;
    end
endmodule

// File: rtl/lsc_compare.sv
module lsc_compare #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int BEW = DW / 8
) (
    input  logic           a_d_req,
    input  logic           a_d_we,
    input  logic [AW-1:0]  a_d_addr,
    input  logic [DW-1:0]  a_d_wdata,
    input  logic [BEW-1:0] a_d_be,
    input  logic           a_i_req,
    input  logic [AW-1:0]  a_i_addr,
    input  logic           b_d_req,
    input  logic           b_d_we,
    input  logic [AW-1:0]  b_d_addr,
    input  logic [DW-1:0]  b_d_wdata,
    input  logic [BEW-1:0] b_d_be,
    input  logic           b_i_req,
    input  logic [AW-1:0]  b_i_addr,
    output logic           miss
);
    logic d_active, i_active, d_diff, i_diff, wr_any;

    always_comb begin
        d_active = a_d_req | b_d_req;
        i_active = a_i_req | b_i_req;
        wr_any   = a_d_we | b_d_we;
        d_diff   = (a_d_req != b_d_req) || (a_d_we != b_d_we) ||
                   (a_d_addr != b_d_addr) || (a_d_be != b_d_be) ||
                   (wr_any && (a_d_wdata != b_d_wdata));
        i_diff   = (a_i_req != b_i_req) || (a_i_addr != b_i_addr);
        miss     = (d_active && d_diff) || (i_active && i_diff);
    end
endmodule

// File: rtl/lsc_ctrl.sv
module lsc_ctrl
    import lsc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss,
    input  logic          rst_ack,
    output logic          diverged,
    output logic          core_rst_req,
    output logic [CW-1:0] div_count
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    lsc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (miss)    state_d = ST_HOLD;
            ST_HOLD: if (rst_ack) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        diverged     = 1'b0;
        core_rst_req = 1'b0;
        unique case (state_q)
            ST_RUN:  ;
            ST_HOLD: begin
                diverged     = 1'b1;
                core_rst_req = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          div_count <= '0;
        else if (miss && div_count != CNT_MAX) div_count <= div_count + 1'b1;
    end
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
    import lsc_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 8,
    parameter int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           c0_d_req,
    input  logic           c0_d_we,
    input  logic [AW-1:0]  c0_d_addr,
    input  logic [DW-1:0]  c0_d_wdata,
    input  logic [BEW-1:0] c0_d_be,
    input  logic           c0_i_req,
    input  logic [AW-1:0]  c0_i_addr,
    input  logic           c1_d_req,
    input  logic           c1_d_we,
    input  logic [AW-1:0]  c1_d_addr,
    input  logic [DW-1:0]  c1_d_wdata,
    input  logic [BEW-1:0] c1_d_be,
    input  logic           c1_i_req,
    input  logic [AW-1:0]  c1_i_addr,
    input  logic           fi_en,
    input  logic           fi_core,
    input  logic [AW-1:0]  fi_addr_mask,
    input  logic [DW-1:0]  fi_data_mask,
    input  logic           rst_ack,
    output logic           bus_d_req,
    output logic           bus_d_we,
    output logic [AW-1:0]  bus_d_addr,
    output logic [DW-1:0]  bus_d_wdata,
    output logic [BEW-1:0] bus_d_be,
    output logic           bus_i_req,
    output logic [AW-1:0]  bus_i_addr,
    output logic           diverged,
    output logic           core_rst_req,
    output logic [CW-1:0]  div_count
);
    logic [AW-1:0] d_addr_raw  [NUM_CORES];
    logic [DW-1:0] d_wdata_raw [NUM_CORES];
    logic [AW-1:0] i_addr_raw  [NUM_CORES];
    logic [AW-1:0] d_addr_f    [NUM_CORES];
    logic [DW-1:0] d_wdata_f   [NUM_CORES];
    logic [AW-1:0] i_addr_f    [NUM_CORES];
    logic          miss;

    always_comb begin
        d_addr_raw[0]  = c0_d_addr;
        d_addr_raw[1]  = c1_d_addr;
        d_wdata_raw[0] = c0_d_wdata;
        d_wdata_raw[1] = c1_d_wdata;
        i_addr_raw[0]  = c0_i_addr;
        i_addr_raw[1]  = c1_i_addr;
    end

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_fi
        lsc_fault_inj #(.AW(AW), .DW(DW), .CORE_ID(g)) u_fi (
            .fi_en        (fi_en),
            .fi_core      (fi_core),
            .fi_addr_mask (fi_addr_mask),
            .fi_data_mask (fi_data_mask),
            .d_addr_in    (d_addr_raw[g]),
            .d_wdata_in   (d_wdata_raw[g]),
            .i_addr_in    (i_addr_raw[g]),
            .d_addr_out   (d_addr_f[g]),
            .d_wdata_out  (d_wdata_f[g]),
            .i_addr_out   (i_addr_f[g])
        );
    end

    lsc_compare #(.AW(AW), .DW(DW), .BEW(BEW)) u_cmp (
        .a_d_req   (c0_d_req),
        .a_d_we    (c0_d_we),
        .a_d_addr  (d_addr_f[0]),
        .a_d_wdata (d_wdata_f[0]),
        .a_d_be    (c0_d_be),
        .a_i_req   (c0_i_req),
        .a_i_addr  (i_addr_f[0]),
        .b_d_req   (c1_d_req),
        .b_d_we    (c1_d_we),
        .b_d_addr  (d_addr_f[1]),
        .b_d_wdata (d_wdata_f[1]),
        .b_d_be    (c1_d_be),
        .b_i_req   (c1_i_req),
        .b_i_addr  (i_addr_f[1]),
        .miss      (miss)
    );

    lsc_ctrl #(.CW(CW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss         (miss),
        .rst_ack      (rst_ack),
        .diverged     (diverged),
        .core_rst_req (core_rst_req),
        .div_count    (div_count)
    );

    always_comb begin
        bus_d_req   = c0_d_req;
        bus_d_we    = c0_d_we;
        bus_d_addr  = d_addr_f[0];
        bus_d_wdata = d_wdata_f[0];
        bus_d_be    = c0_d_be;
        bus_i_req   = c0_i_req;
        bus_i_addr  = i_addr_f[0];
    end
endmodule

// File: rtl/lsc_chk.sv
module lsc_chk #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 8,
    parameter int BEW = DW / 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           c0_d_req,
    input logic [AW-1:0]  c0_d_addr,
    input logic           c0_i_req,
    input logic [AW-1:0]  c0_i_addr,
    input logic           c1_d_req,
    input logic [AW-1:0]  c1_d_addr,
    input logic           c1_i_req,
    input logic [AW-1:0]  c1_i_addr,
    input logic           fi_en,
    input logic           rst_ack,
    input logic [AW-1:0]  bus_d_addr,
    input logic [AW-1:0]  bus_i_addr,
    input logic           diverged,
    input logic           core_rst_req,
    input logic [CW-1:0]  div_count
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    // R2
    bus_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fi_en |-> (bus_d_addr == c0_d_addr) && (bus_i_addr == c0_i_addr));

    // R3
    daddr_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fi_en && c0_d_req && c1_d_req && c0_d_addr != c1_d_addr && !rst_ack)
        |=> diverged);

    // R4
    iaddr_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fi_en && c0_i_req && c1_i_req && c0_i_addr != c1_i_addr && !rst_ack)
        |=> core_rst_req);

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!c0_d_req && !c1_d_req && !c0_i_req && !c1_i_req && !diverged)
        |=> !diverged && $stable(div_count));

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (diverged && !rst_ack) |=> diverged);

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (diverged && rst_ack) |=> !diverged && !core_rst_req);

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_count == CNT_MAX) |=> (div_count == CNT_MAX));

    // R8
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_count != CNT_MAX) |=> (div_count - $past(div_count)) <= 1);
endmodule

bind lockstep_cmp lsc_chk #(.AW(AW), .DW(DW), .CW(CW), .BEW(BEW)) u_lsc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .c0_d_req     (c0_d_req),
    .c0_d_addr    (c0_d_addr),
    .c0_i_req     (c0_i_req),
    .c0_i_addr    (c0_i_addr),
    .c1_d_req     (c1_d_req),
    .c1_d_addr    (c1_d_addr),
    .c1_i_req     (c1_i_req),
    .c1_i_addr    (c1_i_addr),
    .fi_en        (fi_en),
    .rst_ack      (rst_ack),
    .bus_d_addr   (bus_d_addr),
    .bus_i_addr   (bus_i_addr),
    .diverged     (diverged),
    .core_rst_req (core_rst_req),
    .div_count    (div_count)
);

// File: tb/tb_lockstep_cmp.sv
module tb_lockstep_cmp;
    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int CW  = 8;
    localparam int BEW = DW / 8;
    localparam logic [AW-1:0] BASE_A = 32'h1000_2468;
    localparam logic [AW-1:0] BASE_I = 32'h0000_4A50;
    localparam logic [DW-1:0] BASE_W = 32'hCAFE_F00D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic c0_d_req, c0_d_we, c0_i_req, c1_d_req, c1_d_we, c1_i_req;
    logic [AW-1:0] c0_d_addr, c0_i_addr, c1_d_addr, c1_i_addr;
    logic [DW-1:0] c0_d_wdata, c1_d_wdata;
    logic [BEW-1:0] c0_d_be, c1_d_be;
    logic fi_en, fi_core, rst_ack;
    logic [AW-1:0] fi_addr_mask;
    logic [DW-1:0] fi_data_mask;
    logic bus_d_req, bus_d_we, bus_i_req, diverged, core_rst_req;
    logic [AW-1:0] bus_d_addr, bus_i_addr;
    logic [DW-1:0] bus_d_wdata;
    logic [BEW-1:0] bus_d_be;
    logic [CW-1:0] div_count;

    int checks = 0;
    int errors = 0;
    bit exp_div = 0;
    int exp_cnt = 0;

    always #5 clk = ~clk;

    lockstep_cmp #(.AW(AW), .DW(DW), .CW(CW)) dut (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic base();
        c0_d_req = 1; c0_d_we = 1; c0_d_addr = BASE_A; c0_d_wdata = BASE_W; c0_d_be = '1;
        c0_i_req = 1; c0_i_addr = BASE_I;
        c1_d_req = 1; c1_d_we = 1; c1_d_addr = BASE_A; c1_d_wdata = BASE_W; c1_d_be = '1;
        c1_i_req = 1; c1_i_addr = BASE_I;
        fi_en = 0; fi_core = 0; fi_addr_mask = '0; fi_data_mask = '0; rst_ack = 0;
    endtask

    // One clock with the inputs as set; ev = expected divergence this cycle.
    task automatic step(input bit ev, input string tag);
        @(posedge clk);
        #1;
        if (ev && exp_cnt < 255) exp_cnt++;
        exp_div = exp_div ? !rst_ack : ev;
        chk(diverged == exp_div, {tag, " diverged"}, diverged, exp_div);
        chk(core_rst_req == exp_div, {tag, " core_rst_req"}, core_rst_req, exp_div);
        chk(div_count == exp_cnt[CW-1:0], {tag, " div_count"}, div_count, exp_cnt);
    endtask

    task automatic ack_clear(input string tag);
        base();
        rst_ack = 1;
        step(0, tag);
        rst_ack = 0;
    endtask

    initial begin
        base();
        #1;
        chk(diverged == 0 && core_rst_req == 0, "R1 flags in reset", diverged, 0);
        repeat (2) @(posedge clk);
        #2 rst_n = 1;
        chk(div_count == 0, "R1 count after reset", div_count, 0);
        step(0, "R1 agreeing write");

        // R3 data address bits
        for (int b = 0; b < AW; b++) begin
            base(); c1_d_addr = BASE_A ^ (32'h1 << b);
            step(1, "R3 d_addr bit");
            ack_clear("R7 ack after d_addr");
        end
        // R3 byte enables
        for (int b = 0; b < BEW; b++) begin
            base(); c1_d_be[b] = 1'b0;
            step(1, "R3 d_be bit");
            ack_clear("R7 ack after d_be");
        end
        // R3 write data bits
        for (int b = 0; b < DW; b++) begin
            base(); c1_d_wdata = BASE_W ^ (32'h1 << b);
            step(1, "R3 d_wdata bit");
            ack_clear("R7 ack after d_wdata");
        end
        base(); c1_d_we = 0; step(1, "R3 d_we differs"); ack_clear("R7 ack");
        base(); c1_d_req = 0; step(1, "R3 d_req differs"); ack_clear("R7 ack");

        // R4 instruction side
        for (int b = 0; b < AW; b++) begin
            base(); c1_i_addr = BASE_I ^ (32'h1 << b);
            step(1, "R4 i_addr bit");
            ack_clear("R7 ack after i_addr");
        end
        base(); c1_i_req = 0; step(1, "R4 i_req differs"); ack_clear("R7 ack");

        // R5 ignored differences
        base(); c0_d_we = 0; c1_d_we = 0; c1_d_wdata = ~BASE_W;
        step(0, "R5 wdata differs on read");
        base(); c0_d_req = 0; c1_d_req = 0; c1_d_addr = ~BASE_A; c1_d_be = '0;
        step(0, "R5 data side idle");
        base(); c0_i_req = 0; c1_i_req = 0; c1_i_addr = ~BASE_I;
        step(0, "R5 fetch side idle");

        // R6 fault insertion sweep over both cores
        for (int s = 0; s < 2; s++) begin
            for (int b = 0; b < AW; b += 4) begin
                base(); fi_en = 1; fi_core = s[0]; fi_addr_mask = 32'h1 << b;
                #1;
                chk(bus_d_addr == (s == 0 ? BASE_A ^ fi_addr_mask : BASE_A),
                    "R6 R2 bus d_addr under fault", bus_d_addr, BASE_A);
                chk(bus_i_addr == (s == 0 ? BASE_I ^ fi_addr_mask : BASE_I),
                    "R6 R2 bus i_addr under fault", bus_i_addr, BASE_I);
                step(1, "R6 addr fault");
                ack_clear("R7 ack after fault");
            end
            base(); fi_en = 1; fi_core = s[0]; fi_data_mask = 32'h0080_0000;
            #1;
            chk(bus_d_wdata == (s == 0 ? BASE_W ^ 32'h0080_0000 : BASE_W),
                "R6 R2 bus wdata under fault", bus_d_wdata, BASE_W);
            step(1, "R6 data fault");
            ack_clear("R7 ack after data fault");
        end
        base(); fi_addr_mask = '1; fi_data_mask = '1; fi_core = 1;
        #1;
        chk(bus_d_addr == BASE_A && bus_d_wdata == BASE_W, "R6 masks without fi_en",
            bus_d_addr, BASE_A);
        step(0, "R6 fi_en low no effect");

        // R2 core 1 never reaches the bus
        base(); c1_d_addr = 32'h5555_0000; c1_d_we = 0; c1_d_be = 4'h3;
        #1;
        chk(bus_d_addr == BASE_A && bus_d_we == 1 && bus_d_be == 4'hF,
            "R2 bus follows core 0", bus_d_addr, BASE_A);
        step(1, "R2 R3 divergence");

        // R7 sticky across agreeing cycles, ack wins over new divergence
        base(); step(0, "R7 sticky 1");
        base(); c0_d_req = 0; c1_d_req = 0; c0_i_req = 0; c1_i_req = 0;
        step(0, "R7 sticky 2");
        base(); c1_i_addr = 32'h0; rst_ack = 1;
        step(1, "R7 ack with divergence");
        base(); rst_ack = 1; step(0, "R7 ack while running");

        // R8 saturation and no clear by ack
        base(); c1_d_addr = 32'hDEAD_0000;
        for (int k = 0; k < 300; k++) step(1, "R8 saturation run");
        chk(div_count == 8'hFF, "R8 saturated at 255", div_count, 8'hFF);
        ack_clear("R8 ack keeps count");
        chk(div_count == 8'hFF, "R8 count kept after ack", div_count, 8'hFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule